// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the control-port slave of a tuner-style device. It watches the two-wire bus lines (clock and data) with the system clock and recognises START, STOP and repeated START. It responds to one of three 7-bit device addresses, chosen by a strap pin that can be tied low, tied high or left floating. A master writes a register pointer and then any number of data bytes. The pointer advances after every byte. To read, the master sets the pointer, issues a repeated START with the read bit set, and clocks out bytes until it answers with a NACK.

The register map has 22 byte locations. Three of them are read-only: one shows the byte of a 13-entry calibration table selected by another register, and two show status inputs. Every location appears on a flat parallel output bus, so the rest of the chip sees the configuration without any extra logic. A write to the lowest fractional-divider register produces a one-cycle trigger that starts the oscillator band search. The data line is open-drain, so the block only produces a pull-low enable.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The device address is {5'b11000, A2, A1}. The strap encoding on strap_i is 2'b00 (pin low) giving A2A1=00, 2'b01 (pin high) giving 10, and 2'b10 or 2'b11 (pin floating) giving 01, so the write addresses are 0xC0, 0xC4 and 0xC2. A non-matching address gets no ACK, and SDA stays released until the next START.
- R2: Each byte is eight bits, MSB first, sampled on rising SCL and followed by a ninth acknowledge clock. The slave pulls SDA low during the ninth clock after a matching address byte, after the pointer byte and after every written data byte.
- R3: A write transaction is the address byte with R/W=0, then the pointer byte, then data bytes. Each data byte is stored at the current pointer, and the pointer then advances.
- R4: After a repeated START with R/W=1, the slave shifts out the byte at the pointer, MSB first. A master ACK continues with the next register. A master NACK leaves SDA released until STOP or START.
- R5: sda_oe_o (1 = pull SDA low) changes only while SCL is low.
- R6: Registers 0x10, 0x11 and 0x12 are read-only, and writes to them change nothing. 0x11 shows vas_status_i and 0x12 shows gen_status_i.
- R7: Each accepted write to register 0x04 gives exactly one tune_kick_o pulse, one clock wide. No other write gives a pulse.
- R8: Register 0x10 shows calibration byte (i*45 + 23) mod 256, where i is bits [3:0] of register 0x0E, for i from 0 to 12. For i from 13 to 15 it shows zero.
- R9: The pointer advances from 0x15 to 0x00. A pointer above 0x15 reads as zero, ignores writes and advances to 0x00.
- R10: Bits not implemented read as zero. The implemented masks are 0x07:[5:0], 0x09:[4:0], 0x0C:[2:0], 0x0D:[5:0] and 0x0E:[3:0]. All other registers are 8 bits wide.
- R11: A START or STOP in the middle of a byte abandons that byte without storing it. A START returns the slave to address matching, and a STOP releases SDA.
- R12: After reset, all writable registers are zero, SDA is released and tune_kick_o is low.
- R13: cfg_flat_o bits [8i+7:8i] carry the value that a read of register i returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull-low enable for the data line |
| strap_i | input | 2 | Sensed address strap state |
| vas_status_i | input | 8 | Band-search status shown at 0x11 |
| gen_status_i | input | 8 | General status shown at 0x12 |
| tune_kick_o | output | 1 | One-cycle trigger on a write to 0x04 |
| cfg_flat_o | output | 176 | Read view of all 22 registers, byte i at bits [8i+7:8i] |

## Verification
The bench uses the default parameters: 22 registers, a 13-entry calibration table, a two-stage synchroniser and the trigger at 0x04. With these values a single burst can run across the 0x15-to-0x00 wrap, and the selector can reach the three table indices that lie past the end of the table. Random bursts also start at the two pointers above the map. Every strap state is tried against all three addresses, so a wrong address always meets the slave.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int BYTE_W        = 8;
    localparam int DEF_REG_COUNT = 22;
    localparam int DEF_KICK_REG  = 4;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_PTR,
        LS_WDATA,
        LS_RDATA
    } link_state_e;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Strap level -> {A2, A1}
    function automatic logic [1:0] strap_bits(input logic [1:0] s);
        case (s)
            2'b00:   return 2'b00;
            2'b01:   return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    // Implemented bits per register
    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        case (idx)
            7, 13:   return 8'h3F;
            9:       return 8'h1F;
            12:      return 8'h07;
            14:      return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] cal_value(input int idx);
        return BYTE_W'((idx * 45 + 23) % 256);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;
    logic              scl_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    // data edges while the clock stays high are bus conditions
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int REG_COUNT = DEF_REG_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        own_addr,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_o,
    output wr_req_t           wr_o,
    output logic              sda_oe_o
);
    localparam logic [BYTE_W-1:0] LAST_REG = BYTE_W'(REG_COUNT - 1);

    link_state_e       st;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              in_ack, rw, mack, oe;
    wr_req_t           wr;

    function automatic logic [BYTE_W-1:0] next_ptr(input logic [BYTE_W-1:0] p);
        return (p >= LAST_REG) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LS_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            in_ack <= 1'b0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            oe     <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_det) begin
                st     <= LS_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                oe     <= 1'b0;
            end else if (stop_det) begin
                st     <= LS_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                oe     <= 1'b0;
            end else if (st != LS_IDLE) begin
                if (scl_rise) begin
                    if (in_ack) begin
                        if (st == LS_RDATA) mack <= ~sda_lvl;
                    end else begin
                        if (st != LS_RDATA) shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (in_ack) begin
                        // end of the ninth clock
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        oe     <= 1'b0;
                        case (st)
                            LS_ADDR: begin
                                if (rw) begin
                                    st    <= LS_RDATA;
                                    shreg <= rd_data;
                                    oe    <= ~rd_data[BYTE_W-1];
                                end else begin
                                    st <= LS_PTR;
                                end
                            end
                            LS_PTR: st <= LS_WDATA;
                            LS_RDATA: begin
                                if (mack) begin
                                    shreg <= rd_data;
                                    oe    <= ~rd_data[BYTE_W-1];
                                end else begin
                                    st <= LS_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end else if (cnt == 4'd8) begin
                        in_ack <= 1'b1;
                        case (st)
                            LS_ADDR: begin
                                if (shreg[BYTE_W-1:1] == own_addr) begin
                                    oe <= 1'b1;
                                    rw <= shreg[0];
                                end else begin
                                    st     <= LS_IDLE;
                                    in_ack <= 1'b0;
                                end
                            end
                            LS_PTR: begin
                                oe  <= 1'b1;
                                ptr <= shreg;
                            end
                            LS_WDATA: begin
                                oe      <= 1'b1;
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= shreg;
                                ptr     <= next_ptr(ptr);
                            end
                            LS_RDATA: begin
                                oe  <= 1'b0;
                                ptr <= next_ptr(ptr);
                            end
                            default: ;
                        endcase
                    end else if (st == LS_RDATA && cnt != 4'd0) begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        oe    <= ~shreg[BYTE_W-2];
                    end
                end
            end
        end
    end

    assign ptr_o    = ptr;
    assign wr_o     = wr;
    assign sda_oe_o = oe;
endmodule

// File: rtl/cal_rom.sv
module cal_rom
    import cfg_i2c_pkg::*;
#(
    parameter int DEPTH = 13,
    parameter int AW    = 4
) (
    input  logic [AW-1:0]     sel_i,
    output logic [BYTE_W-1:0] data_o
);
    always_comb begin
        data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel_i == AW'(i)) data_o = cal_value(i);
        end
    end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfg_i2c_pkg::*;
#(
    parameter int REG_COUNT    = DEF_REG_COUNT,
    parameter int ROM_DEPTH    = 13,
    parameter int KICK_REG     = DEF_KICK_REG,
    parameter int ROM_SEL_REG  = 14,
    parameter int ROM_DATA_REG = 16,
    parameter int STAT_A_REG   = 17,
    parameter int STAT_B_REG   = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     wr_i,
    input  logic [BYTE_W-1:0]           rd_ptr_i,
    output logic [BYTE_W-1:0]           rd_data_o,
    input  logic [BYTE_W-1:0]           stat_a_i,
    input  logic [BYTE_W-1:0]           stat_b_i,
    output logic [REG_COUNT*BYTE_W-1:0] view_o,
    output logic                        kick_o
);
    localparam int ROM_AW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

    logic [REG_COUNT-1:0][BYTE_W-1:0] store;
    logic [REG_COUNT-1:0][BYTE_W-1:0] view;
    logic [BYTE_W-1:0]                rom_byte;
    logic                             kick;

    function automatic logic is_ro(input int idx);
        return (idx == ROM_DATA_REG) || (idx == STAT_A_REG) || (idx == STAT_B_REG);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
            kick  <= 1'b0;
        end else begin
            kick <= wr_i.en && (wr_i.addr == BYTE_W'(KICK_REG));
            for (int i = 0; i < REG_COUNT; i++) begin
                if (wr_i.en && wr_i.addr == BYTE_W'(i) && !is_ro(i))
                    store[i] <= wr_i.data & reg_mask(i);
            end
        end
    end

    cal_rom #(
        .DEPTH(ROM_DEPTH),
        .AW   (ROM_AW)
    ) u_cal_rom (
        .sel_i (store[ROM_SEL_REG][ROM_AW-1:0]),
        .data_o(rom_byte)
    );

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_view
        if (g == ROM_DATA_REG) begin : g_rom
            assign view[g] = rom_byte;
        end else if (g == STAT_A_REG) begin : g_sa
            assign view[g] = stat_a_i;
        end else if (g == STAT_B_REG) begin : g_sb
            assign view[g] = stat_b_i;
        end else begin : g_rw
            assign view[g] = store[g];
        end
        assign view_o[g*BYTE_W +: BYTE_W] = view[g];
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_ptr_i == BYTE_W'(i)) rd_data_o = view[i];
        end
    end

    assign kick_o = kick;
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int         REG_COUNT    = DEF_REG_COUNT,
    parameter int         ROM_DEPTH    = 13,
    parameter int         SYNC_STAGES  = 2,
    parameter logic [4:0] DEV_PREFIX   = 5'b11000,
    parameter int         KICK_REG     = DEF_KICK_REG,
    parameter int         ROM_SEL_REG  = 14,
    parameter int         ROM_DATA_REG = 16,
    parameter int         STAT_A_REG   = 17,
    parameter int         STAT_B_REG   = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe_o,
    input  logic [1:0]                  strap_i,
    input  logic [BYTE_W-1:0]           vas_status_i,
    input  logic [BYTE_W-1:0]           gen_status_i,
    output logic                        tune_kick_o,
    output logic [REG_COUNT*BYTE_W-1:0] cfg_flat_o
);
    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]        own_addr;
    logic [BYTE_W-1:0] ptr, rd_data;
    wr_req_t           wr_req;

    assign own_addr = {DEV_PREFIX, strap_bits(strap_i)};

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_link_fsm #(
        .REG_COUNT(REG_COUNT)
    ) u_link (
        .clk      (clk),
        .rst      (rst),
        .own_addr (own_addr),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .ptr_o    (ptr),
        .wr_o     (wr_req),
        .sda_oe_o (sda_oe_o)
    );

    cfg_reg_file #(
        .REG_COUNT   (REG_COUNT),
        .ROM_DEPTH   (ROM_DEPTH),
        .KICK_REG    (KICK_REG),
        .ROM_SEL_REG (ROM_SEL_REG),
        .ROM_DATA_REG(ROM_DATA_REG),
        .STAT_A_REG  (STAT_A_REG),
        .STAT_B_REG  (STAT_B_REG)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr_req),
        .rd_ptr_i (ptr),
        .rd_data_o(rd_data),
        .stat_a_i (vas_status_i),
        .stat_b_i (gen_status_i),
        .view_o   (cfg_flat_o),
        .kick_o   (tune_kick_o)
    );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
    import cfg_i2c_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    scl_i,
    input logic    sda_oe_o,
    input logic    tune_kick_o,
    input wr_req_t wr_req,
    input logic    stop_det
);
    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tune_kick_o |=> !tune_kick_o); // R7

    AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tune_kick_o |-> $past(wr_req.en && wr_req.addr == BYTE_W'(DEF_KICK_REG))); // R7

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe_o); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !tune_kick_o)); // R12
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .tune_kick_o(tune_kick_o),
    .wr_req     (wr_req),
    .stop_det   (stop_det)
);

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;
    localparam int NREG = 22;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic [7:0] stat_a = 8'h00, stat_b = 8'h00;
    logic sda_oe, kick;
    logic [NREG*8-1:0] flat;
    wire  sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    cfg_i2c_slave u_cfg_i2c_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .strap_i(strap), .vas_status_i(stat_a), .gen_status_i(stat_b),
        .tune_kick_o(kick), .cfg_flat_o(flat)
    );

    int tests = 0, fails = 0;
    int kick_seen = 0, kick_wide = 0, kick_exp = 0, bad_edge = 0, oe_cycles = 0;
    logic kick_q = 1'b0, oe_q = 1'b0;
    bit done = 0;
    logic [7:0] exp_reg [0:NREG-1];
    logic [7:0] wbuf [0:31];

    always @(posedge clk) begin
        if (!rst) begin
            if (kick) kick_seen++;
            if (kick && kick_q) kick_wide++;
            if (sda_oe != oe_q && scl_m) bad_edge++;
            if (sda_oe) oe_cycles++;
        end
        kick_q <= kick;
        oe_q   <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_mask(input int i);
        case (i)
            7, 13: return 8'h3F;
            9: return 8'h1F;
            12: return 8'h07;
            14: return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] m_rom(input int i);
        return (i <= 12) ? 8'((i * 45 + 23) % 256) : 8'h00;
    endfunction

    function automatic logic [7:0] m_view(input int p);
        if (p >= NREG) return 8'h00;
        if (p == 16) return m_rom(int'(exp_reg[14][3:0]));
        if (p == 17) return stat_a;
        if (p == 18) return stat_b;
        return exp_reg[p];
    endfunction

    function automatic int m_next(input int p);
        return (p >= NREG - 1) ? 0 : p + 1;
    endfunction

    function automatic logic [6:0] dev_of(input logic [1:0] s);
        case (s)
            2'b00: return 7'h60;
            2'b01: return 7'h62;
            default: return 7'h61;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        ack = ~sda_bus;
        tick(H / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H / 2);
            b[i] = sda_bus;
            tick(H / 2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input int ptr, input int n);
        bit ack;
        int p = ptr;
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        check(ack, "R1 address ACK", ack, 1);
        send_byte(8'(ptr), ack);
        check(ack, "R2 pointer ACK", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            check(ack, "R2 data ACK", ack, 1);
            if (p < NREG && p != 16 && p != 17 && p != 18) exp_reg[p] = wbuf[k] & m_mask(p);
            if (p == 4) kick_exp++;
            p = m_next(p);
        end
        bus_stop();
    endtask

    task automatic do_read(input int ptr, input int n, input string req);
        bit ack;
        logic [7:0] b;
        int p = ptr;
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        send_byte(8'(ptr), ack);
        bus_start();
        send_byte({dev_of(strap), 1'b1}, ack);
        check(ack, "R4 read address ACK", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            check(b == m_view(p), req, b, m_view(p));
            p = m_next(p);
        end
        bus_stop();
        check(!sda_oe, "R4 released after NACK", sda_oe, 0);
    endtask

    task automatic check_flat(input string req);
        for (int i = 0; i < NREG; i++)
            check(flat[i*8 +: 8] == m_view(i), req, flat[i*8 +: 8], m_view(i));
    endtask

    initial begin
        bit ack;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        stat_a = 8'h5C; stat_b = 8'hA3;
        tick(5);
        rst = 1'b0;
        tick(4);
        // reset state
        check(!sda_oe, "R12 SDA released", sda_oe, 0);
        check(!kick, "R12 kick low", kick, 0);
        check_flat("R12 R13 reset view");

        // addressing under all strap states
        for (int s = 0; s < 3; s++) begin
            strap = 2'(s);
            wbuf[0] = 8'(8'h11 * (s + 1));
            do_write(0, 1);
            do_read(0, 1, "R3 strap write");
            for (int o = 0; o < 3; o++) begin
                if (o != s) begin
                    bus_start();
                    oe_cycles = 0;
                    send_byte({dev_of(2'(o)), 1'b0}, ack);
                    check(!ack, "R1 foreign address NACK", ack, 0);
                    send_byte(8'h00, ack);
                    send_byte(8'hEE, ack);
                    bus_stop();
                    check(oe_cycles == 0, "R1 SDA stays released", oe_cycles, 0);
                end
            end
            do_read(0, 1, "R1 foreign write ignored");
        end
        strap = 2'b11;
        do_read(0, 1, "R1 strap 11 acts as floating");

        // calibration window
        for (int i = 0; i < 16; i++) begin
            wbuf[0] = 8'(i);
            do_write(14, 1);
            do_read(16, 1, "R8 calibration byte");
            check(flat[16*8 +: 8] == m_rom(i), "R8 R13 flat view", flat[16*8 +: 8], m_rom(i));
        end

        // read-only registers
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        do_write(16, 3);
        do_read(15, 5, "R6 read-only unchanged");
        check_flat("R6 R13 view after RO write");

        // masks: write all ones everywhere
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'hFF;
        do_write(0, NREG);
        do_read(0, NREG, "R10 masked bits read zero");
        check_flat("R10 R13 masked view");

        // wrap
        wbuf[0] = 8'h3A; wbuf[1] = 8'h71; wbuf[2] = 8'h9E;
        do_write(21, 3);
        do_read(20, 4, "R9 pointer wrap");

        // STOP mid-byte
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        send_byte(8'h03, ack);
        send_bits(8'h00, 4);
        bus_stop();
        check(!sda_oe, "R11 STOP releases", sda_oe, 0);
        do_read(3, 1, "R11 STOP abort keeps register");
        // START mid-byte
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        send_byte(8'h05, ack);
        send_bits(8'h00, 3);
        wbuf[0] = 8'h42;
        do_write(6, 1);
        do_read(5, 2, "R11 START abort and restart");

        // kick directed
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        do_write(3, 4);

        // random bursts
        for (int t = 0; t < 20; t++) begin
            int p, n;
            strap  = 2'($urandom_range(0, 3));
            stat_a = 8'($urandom);
            stat_b = 8'($urandom);
            p = $urandom_range(0, 23);
            n = $urandom_range(1, 5);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(p, n);
            do_read(p, n + 1, "R3 R4 random burst");
        end
        check_flat("R13 final view");

        tick(4);
        check(kick_seen == kick_exp, "R7 kick count", kick_seen, kick_exp);
        check(kick_wide == 0, "R7 kick width", kick_wide, 0);
        check(bad_edge == 0, "R5 SDA edges with SCL low", bad_edge, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog expired actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule